// File: doc/BRIEF.md
# Scan Code Hex Text Writer

This block sits between a keyboard byte receiver and a character RAM. The receiver raises a ready flag while it holds a byte and drops that byte when it sees a low read strobe. The writer accepts each byte and spells it out as printable text in the character RAM: the upper nibble as a hex digit, then the lower nibble as a hex digit, then a blank. Each of the three characters goes into its own RAM location. The write pointer moves forward by one after every character.

A key press followed by its release arrives as a short run of bytes, for example 0x4b, 0xf0, 0x4b. On the screen this appears as the string `4b f0 4b `. No byte is dropped, even when the receiver offers the next byte straight after the previous one. The write pointer covers an 80-column by 60-row text buffer and wraps to the first location after the last one.

Top module: `hex_text_writer`

## Requirements
- R1: While reset is asserted, and after it is released until the first byte arrives, `ram_we` is 0, `rx_rd_n` is 1 and `ram_addr` is 0.
- R2: A byte is accepted only while `rx_ready` is 1. The writer then drives `rx_rd_n` low for exactly one clock, and `ram_we` is 1 in that same cycle. The number of strobes equals the number of bytes offered.
- R3: Each accepted byte produces exactly three consecutive write cycles. Their order is high-nibble digit, low-nibble digit, then the space code 0x20.
- R4: A nibble n in 0..9 is written as 0x30+n. A nibble in 10..15 is written as the lowercase letter 0x61+(n-10).
- R5: `ram_addr` advances by one after each write cycle and holds when no write takes place. After location COLS*ROWS-1 (4799 by default) it returns to 0.
- R6: The byte is captured on the cycle it is accepted. Changes on `rx_byte` during the three writes do not alter the characters written.
- R7: No new byte is accepted before the space of the current byte is written. A strobe occurs only after a whole number of three-character groups.
- R8: The bytes 0x4b, 0xf0, 0x4b offered back to back produce exactly the nine characters "4b f0 4b " at consecutive addresses.
- R9: While `rx_ready` stays 0, no write and no strobe occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| rx_ready | input | 1 | The receiver holds a byte |
| rx_byte | input | 8 | Byte offered by the receiver |
| rx_rd_n | output | 1 | Active-low one-clock strobe that consumes the offered byte |
| ram_we | output | 1 | Character RAM write enable; the write takes place on the rising edge |
| ram_addr | output | 13 | Character RAM write address |
| ram_char | output | 8 | ASCII character to write |

## Verification
The bound checker looks at every cycle. It checks that the strobe lasts one clock and coincides with a write cycle. It checks that a strobe follows only an idle cycle or a space, and that the address steps and wraps on every write and holds otherwise. It also checks that every written character is a hex digit or a space.

Some behaviours only the bench scenarios can show. These are the exact character sequence for given bytes and the immunity to `rx_byte` changing in mid-group. They also include the absence of lost bytes on back-to-back input, and the wrap after a full buffer of writes. The bench shows these by comparing each write with text computed from the offered bytes.

// File: rtl/hexw_pkg.sv
package hexw_pkg;
  localparam logic [7:0] BLANK_CHAR = 8'h20;

  typedef enum logic [1:0] {
    SLOT_HI = 2'd0,
    SLOT_LO = 2'd1,
    SLOT_SP = 2'd2
  } slot_t;

  function automatic logic [7:0] nib_to_hex(input logic [3:0] n);
    logic [7:0] r;
    if (n < 4'd10) r = 8'h30 + {4'h0, n};
    else           r = 8'h57 + {4'h0, n};
    return r;
  endfunction
endpackage

// File: rtl/hexw_rst_sync.sv
module hexw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/hexw_seq.sv
module hexw_seq
  import hexw_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ready,
  input  logic [BW-1:0] rx_byte,
  output logic          rd_n,
  output logic          we,
  output slot_t         slot,
  output logic [BW-1:0] hold
);
  logic          accept;
  logic          last_slot;
  logic          rd_n_d, we_d;
  slot_t         slot_d;
  logic [BW-1:0] hold_d;

  assign last_slot = (slot == SLOT_SP);
  // Accept while idle, or on the cycle the space is being written.
  assign accept    = rx_ready && (!we || last_slot);

  always_comb begin
    rd_n_d = 1'b1;
    we_d   = we;
    slot_d = slot;
    hold_d = hold;
    if (accept) begin
      rd_n_d = 1'b0;
      we_d   = 1'b1;
      slot_d = SLOT_HI;
      hold_d = rx_byte;
    end else if (we) begin
      unique case (slot)
        SLOT_HI: slot_d = SLOT_LO;
        SLOT_LO: slot_d = SLOT_SP;
        default: begin
          slot_d = SLOT_HI;
          we_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n <= 1'b1;
      we   <= 1'b0;
      slot <= SLOT_HI;
      hold <= '0;
    end else begin
      rd_n <= rd_n_d;
      we   <= we_d;
      slot <= slot_d;
      hold <= hold_d;
    end
  end
endmodule

// File: rtl/hexw_addr.sv
module hexw_addr #(
  parameter int DEPTH = 4800,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (step) addr_d = (addr == LAST) ? '0 : addr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (step) addr <= addr_d;
  end
endmodule

// File: rtl/hexw_conv.sv
module hexw_conv
  import hexw_pkg::*;
(
  input  logic [7:0] byte_in,
  input  slot_t      slot,
  output logic [7:0] char_out
);
  always_comb begin
    unique case (slot)
      SLOT_HI: char_out = nib_to_hex(byte_in[7:4]);
      SLOT_LO: char_out = nib_to_hex(byte_in[3:0]);
      default: char_out = BLANK_CHAR;
    endcase
  end
endmodule

// File: rtl/hex_text_writer.sv
module hex_text_writer
  import hexw_pkg::*;
#(
  parameter int COLS       = 80,
  parameter int ROWS       = 60,
  parameter int SYNC_STAGE = 2,
  localparam int DEPTH     = COLS * ROWS,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ready,
  input  logic [7:0]    rx_byte,
  output logic          rx_rd_n,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_char
);
  logic  srst_n;
  slot_t slot;
  logic [7:0] hold;

  hexw_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  hexw_seq #(.BW(8)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .rx_ready (rx_ready),
    .rx_byte  (rx_byte),
    .rd_n     (rx_rd_n),
    .we       (ram_we),
    .slot     (slot),
    .hold     (hold)
  );

  hexw_addr #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (srst_n),
    .step  (ram_we),
    .addr  (ram_addr)
  );

  hexw_conv u_conv (
    .byte_in  (hold),
    .slot     (slot),
    .char_out (ram_char)
  );
endmodule

// File: rtl/hex_text_writer_chk.sv
module hex_text_writer_chk #(
  parameter int DEPTH = 4800,
  parameter int AW    = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_rd_n,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [7:0]    ram_char
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rd_n |=> rx_rd_n); // R2
  AST_STROBE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rd_n |-> ram_we); // R2
  AST_STROBE_AFTER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rd_n |-> (!$past(ram_we) || $past(ram_char) == 8'h20)); // R7
  AST_SPACE_ENDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_char == 8'h20) |=> (!ram_we || !rx_rd_n)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ram_addr == (($past(ram_addr) == LAST) ? '0 : $past(ram_addr) + AW'(1))); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we |=> $stable(ram_addr)); // R5
  AST_CHAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_char >= 8'h30 && ram_char <= 8'h39) ||
                (ram_char >= 8'h61 && ram_char <= 8'h66) || ram_char == 8'h20)); // R4
endmodule

bind hex_text_writer hex_text_writer_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_rd_n  (rx_rd_n),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .ram_char (ram_char)
);

// File: tb/hex_text_writer_tb_top.sv
module hex_text_writer_tb_top;
  localparam int DEPTH = 4800;
  localparam int QN    = 4096;

  logic        clk;
  logic        rst_n;
  logic        rx_ready;
  logic [7:0]  rx_byte;
  logic        rx_rd_n;
  logic        ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_char;

  logic [7:0] q   [0:QN-1];
  logic [7:0] txt [0:8191];
  logic [7:0] junk;
  int wp, rp, nwr, nstb, n_cmp, n_bad;
  logic prev_rd_n;
  bit   run;

  hex_text_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rx_rd_n(rx_rd_n), .ram_we(ram_we), .ram_addr(ram_addr), .ram_char(ram_char)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign rx_ready = (rp != wp);
  assign rx_byte  = rx_ready ? q[rp % QN] : junk;

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h61 + 8'(n - 10);
  endfunction

  function automatic logic [7:0] exp_char(input logic [7:0] b, input int pos);
    if (pos == 0) return hexc(b[7:4]);
    if (pos == 1) return hexc(b[3:0]);
    return 8'h20;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic push(input logic [7:0] b);
    @(posedge clk); #1;
    q[wp % QN] = b;
    wp++;
  endtask

  task automatic drain();
    while (rp != wp) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  // Receiver model and write monitor, sampled at the falling edge.
  always @(negedge clk) begin
    junk <= 8'($urandom);
    if (run && rst_n) begin
      if (!rx_rd_n) begin
        check(nwr % 3 == 0, "R7 strobe inside a group", nwr % 3, 0);
        check(prev_rd_n, "R2 strobe longer than one clock", 0, 1);
        check(rx_ready, "R9 strobe without ready", 0, 1);
        check(ram_we, "R2 write with strobe", ram_we, 1);
        if (rx_ready) rp++;
        nstb++;
      end
      if (ram_we) begin
        check(ram_char == exp_char(q[(nwr / 3) % QN], nwr % 3),
              (nwr % 3 == 2) ? "R3 space" : "R4 R6 digit",
              ram_char, exp_char(q[(nwr / 3) % QN], nwr % 3));
        check(ram_addr == 13'(nwr % DEPTH), "R5 address", ram_addr, nwr % DEPTH);
        txt[nwr % 8192] = ram_char;
        nwr++;
      end
    end
    prev_rd_n <= rx_rd_n;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nwr, 0);
    summary();
  end

  initial begin
    int w0, s0;
    logic [7:0] key_txt [0:8];
    void'($urandom(32'h5eed_0042));
    wp = 0; rp = 0; nwr = 0; nstb = 0; n_cmp = 0; n_bad = 0; run = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!ram_we && rx_rd_n && ram_addr == 0, "R1 during reset", {ram_we, rx_rd_n}, 1);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ram_we == 0, "R1 we after reset", ram_we, 0);
    check(rx_rd_n == 1, "R1 strobe after reset", rx_rd_n, 1);
    check(ram_addr == 0, "R1 address after reset", ram_addr, 0);
    run = 1;

    // R9: idle, no ready
    w0 = nwr; s0 = nstb;
    repeat (20) @(posedge clk);
    check(nwr == w0, "R9 no writes while idle", nwr - w0, 0);
    check(nstb == s0, "R9 no strobes while idle", nstb - s0, 0);

    // R8: make / break sequence back to back
    w0 = nwr; s0 = nstb;
    @(posedge clk); #1;
    q[wp % QN] = 8'h4b; q[(wp + 1) % QN] = 8'hf0; q[(wp + 2) % QN] = 8'h4b;
    wp += 3;
    drain();
    check(nwr - w0 == 9, "R8 character count", nwr - w0, 9);
    check(nstb - s0 == 3, "R2 strobe count", nstb - s0, 3);
    key_txt = '{8'h34, 8'h62, 8'h20, 8'h66, 8'h30, 8'h20, 8'h34, 8'h62, 8'h20};
    for (int i = 0; i < 9; i++)
      check(txt[(w0 + i) % 8192] == key_txt[i], "R8 text", txt[(w0 + i) % 8192], key_txt[i]);

    // R4: every nibble value, isolated bytes
    for (int i = 0; i < 8; i++) begin
      push(8'((2 * i) << 4 | (2 * i + 1)));
      repeat (5) @(posedge clk);
    end
    push(8'h00); push(8'hff); push(8'h9a);
    drain();

    // R5/R6: random bytes with random gaps past the address wrap
    for (int i = 0; i < 1700; i++) begin
      push(8'($urandom));
      repeat ($urandom % 4) @(posedge clk);
    end
    drain();
    check(nstb == wp, "R2 strobes equal bytes", nstb, wp);
    check(nwr == 3 * wp, "R3 three writes per byte", nwr, 3 * wp);
    check(nwr > DEPTH, "R5 wrap reached", nwr, DEPTH);
    @(negedge clk);
    check(ram_addr == 13'(nwr % DEPTH), "R5 address after wrap", ram_addr, nwr % DEPTH);
    summary();
  end
endmodule